// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block drives the read side of a raster display pipeline. It walks a framebuffer one field at a time, issuing one 32-bit word read per cycle slot, and turns the returned words into a stream of 24-bit RGB pixels. The field and line strobes come from an external raster timing generator. Base addresses, the packed size word and the mode word come from configuration registers. Every address is a word address.

Each field begins at its own base address. The long field uses one base and the short field uses the other. A per-line stride lets interlaced output skip alternate framebuffer lines. The short-field base is placed one line past the long-field base, and the stride is raised by one line's word count. Configuration is copied into shadow registers on each field start, so a write made during a field cannot tear the picture. Memory is modelled as a synchronous read port with a fixed latency of `RD_LAT` cycles.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset, `rd_req`, `pix_valid` and `pix_rgb` are all zero. No read is issued, even if `line_start` pulses, until the first `field_start`.
- R2: On `field_start`, the field's first read address is `cfg_base_short` when `field_short` is 1 and `cfg_base_long` when it is 0.
- R3: On each accepted line, the block issues `cfg_size[9:0]`+1 reads to consecutive rising word addresses. Data for a read is taken from `rd_data` `RD_LAT` cycles after its `rd_req`. Its first pixel appears on the following cycle.
- R4: The first address of each later line equals the last address of the previous line plus the stride `cfg_size[29:20]`. A stride of 1 therefore gives contiguous lines.
- R5: Each field fetches at most `cfg_size[19:10]`+1 lines. Further `line_start` pulses are ignored until the next `field_start`. `line_start` is honoured from the second cycle after `field_start`, and is ignored while a line is still being fetched.
- R6: The format is selected by `cfg_mode[3:2]`. Value 0 means 16-bit 5:5:5 (R=[14:10], G=[9:5], B=[4:0]) and value 1 means 16-bit 5:6:5 (R=[15:11], G=[10:5], B=[4:0]). Each word gives two pixels, the low half first. Each channel is widened to 8 bits by copying its top bits into its low bits. In these formats reads are never issued in two back-to-back cycles.
- R7: Format 2 is packed 24-bit. Bytes are taken from the words of a line in little-endian order, three bytes per pixel, in the order B, G, R. Three words give four pixels. Byte grouping restarts at every line, and any trailing bytes that do not complete a pixel are dropped. No more than three reads are issued in any four consecutive cycles.
- R8: Format 3 gives one pixel per word, with R=[23:16], G=[15:8], B=[7:0]. Bits [31:24] are ignored.
- R9: If `cfg_mode[0]` (enable) is 0 when a field starts, no reads are issued and `pix_valid` stays low for that field.
- R10: Changes to the base, size or mode inputs during a field have no effect until the next `field_start`.
- R11: `pix_rgb` is zero in every cycle in which `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_long | input | ADDR_W | Word address where the long field starts |
| cfg_base_short | input | ADDR_W | Word address where the short field starts |
| cfg_size | input | 32 | Size word: last word index [9:0], last line index [19:10], stride [29:20] |
| cfg_mode | input | 32 | Mode word: enable [0], pixel format [3:2] |
| field_start | input | 1 | One-cycle field start strobe |
| field_short | input | 1 | Field kind, sampled together with `field_start` |
| line_start | input | 1 | One-cycle line start strobe |
| rd_data | input | 32 | Read data, valid `RD_LAT` cycles after the request |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Word address of the read |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Pixel output as {R, G, B}, 8 bits per channel |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a field. With a correct block it leaves no trace, so the bench rewrites every configuration input straight after the first line strobe of a field. It then checks that the remaining lines still follow the values held when the field began. A second hard case is a line strobe beyond the programmed line count. The bench sends surplus strobes in an interlaced short field and flags any unexpected read. Packed 24-bit lines whose word counts are not a multiple of three exercise the dropping of leftover bytes at the line boundary.

// File: rtl/scan_pkg.sv
// Shared types and helpers for the scanout address generator.
// Assumes 32-bit memory words and 10-bit fields in the size word.
package scan_pkg;

    localparam int WORD_W = 32;
    localparam int FLD_W  = 10;
    localparam int PIX_W  = 24;

    typedef enum logic [1:0] {
        FMT_555    = 2'd0,
        FMT_565    = 2'd1,
        FMT_PACK24 = 2'd2,
        FMT_WIDE32 = 2'd3
    } pix_fmt_e;

    // Configuration as held for the duration of one field
    typedef struct packed {
        logic             en;
        pix_fmt_e         fmt;
        logic [FLD_W-1:0] last_word;
        logic [FLD_W-1:0] last_line;
        logic [FLD_W-1:0] stride;
    } scan_cfg_t;

    // Widens a 16-bit pixel to 8:8:8 by replicating the top bits of each channel
    function automatic logic [PIX_W-1:0] widen16(input logic [15:0] p, input pix_fmt_e f);
        logic [7:0] r8;
        logic [7:0] g8;
        logic [7:0] b8;
        if (f == FMT_565) begin
            r8 = {p[15:11], p[15:13]};
            g8 = {p[10:5],  p[10:9]};
        end else begin
            r8 = {p[14:10], p[14:12]};
            g8 = {p[9:5],   p[9:7]};
        end
        b8 = {p[4:0], p[4:2]};
        return {r8, g8, b8};
    endfunction

endpackage

// File: rtl/scan_cfg_shadow.sv
// Shadow register stage: captures the configuration inputs on a field start
// and emits a one-cycle load pulse on the following cycle.
// Assumes field_start is a single-cycle strobe.
module scan_cfg_shadow
    import scan_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 field_start,
    input  logic                 field_short,
    input  logic [ADDR_W-1:0]    base_long,
    input  logic [ADDR_W-1:0]    base_short,
    input  logic [WORD_W-1:0]    size_word,
    input  logic [WORD_W-1:0]    mode_word,
    output scan_cfg_t            cfg,
    output logic [ADDR_W-1:0]    start_addr,
    output logic                 field_load
);

    localparam int LWORD_LSB = 0;
    localparam int LLINE_LSB = FLD_W;
    localparam int STRD_LSB  = 2 * FLD_W;
    localparam int SIZE_TOP  = 3 * FLD_W;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{size_word[WORD_W-1:SIZE_TOP], mode_word[WORD_W-1:4], mode_word[1]};

    // Capture configuration and field base at each field start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            start_addr <= '0;
            field_load <= 1'b0;
        end else begin
            field_load <= field_start;
            if (field_start) begin
                cfg.en        <= mode_word[0];
                cfg.fmt       <= pix_fmt_e'(mode_word[3:2]);
                cfg.last_word <= size_word[LWORD_LSB +: FLD_W];
                cfg.last_line <= size_word[LLINE_LSB +: FLD_W];
                cfg.stride    <= size_word[STRD_LSB +: FLD_W];
                start_addr    <= field_short ? base_short : base_long;
            end
        end
    end

endmodule

// File: rtl/scan_fetch.sv
// Fetch sequencer: walks the field line by line, issuing one word read per
// permitted slot. The slot pattern paces reads to the unpacker's output rate.
// Assumes line_start strobes arrive only after the previous line has finished.
module scan_fetch
    import scan_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_cfg_t         cfg,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              field_load,
    input  logic              line_start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_first
);

    typedef enum logic [1:0] {F_OFF, F_WAIT, F_RUN} fstate_e;

    fstate_e          state;
    logic [ADDR_W-1:0] ptr;
    logic [FLD_W-1:0] word_cnt;
    logic [FLD_W-1:0] line_cnt;
    logic [1:0]       slot;
    logic [1:0]       slot_next;
    logic             slot_ok;
    logic             issue;
    logic             at_last_word;

    // Decide whether this cycle's slot may carry a read, per pixel format
    always_comb begin
        case (cfg.fmt)
            FMT_555, FMT_565: begin
                slot_ok   = (slot[0] == 1'b0);
                slot_next = {1'b0, ~slot[0]};
            end
            FMT_PACK24: begin
                slot_ok   = (slot != 2'd3);
                slot_next = slot + 2'd1;
            end
            default: begin
                slot_ok   = 1'b1;
                slot_next = 2'd0;
            end
        endcase
    end

    assign issue        = (state == F_RUN) && slot_ok;
    assign at_last_word = (word_cnt == cfg.last_word);

    // Line and word sequencing, address advance and read issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= F_OFF;
            ptr      <= '0;
            word_cnt <= '0;
            line_cnt <= '0;
            slot     <= '0;
            rd_req   <= 1'b0;
            rd_addr  <= '0;
            rd_first <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            if (field_load) begin
                ptr      <= start_addr;
                line_cnt <= '0;
                state    <= cfg.en ? F_WAIT : F_OFF;
            end else begin
                case (state)
                    F_WAIT: begin
                        if (line_start) begin
                            state    <= F_RUN;
                            word_cnt <= '0;
                            slot     <= '0;
                        end
                    end
                    F_RUN: begin
                        slot <= slot_next;
                        if (issue) begin
                            rd_req   <= 1'b1;
                            rd_addr  <= ptr;
                            rd_first <= (word_cnt == '0);
                            if (at_last_word) begin
                                ptr <= ptr + ADDR_W'(cfg.stride);
                                if (line_cnt == cfg.last_line) begin
                                    state <= F_OFF;
                                end else begin
                                    line_cnt <= line_cnt + FLD_W'(1);
                                    state    <= F_WAIT;
                                end
                            end else begin
                                ptr      <= ptr + ADDR_W'(1);
                                word_cnt <= word_cnt + FLD_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/scan_unpack.sv
// Pixel unpacker: tracks reads through the fixed memory latency and turns
// each returned word into one or two pixels for the selected format.
// Assumes the fetch pacing leaves an idle data cycle after every word that
// yields a second pixel.
module scan_unpack
    import scan_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  pix_fmt_e          fmt,
    input  logic              rd_req,
    input  logic              rd_first,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_rgb
);

    logic [RD_LAT-1:0] vld_pipe;
    logic [RD_LAT-1:0] first_pipe;
    logic              data_vld;
    logic              data_first;

    generate
        if (RD_LAT == 1) begin : g_lat_one
            // Single-stage latency tracking
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_pipe   <= '0;
                    first_pipe <= '0;
                end else begin
                    vld_pipe   <= rd_req;
                    first_pipe <= rd_req & rd_first;
                end
            end
        end else begin : g_lat_many
            // Multi-stage latency tracking
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_pipe   <= '0;
                    first_pipe <= '0;
                end else begin
                    vld_pipe   <= {vld_pipe[RD_LAT-2:0], rd_req};
                    first_pipe <= {first_pipe[RD_LAT-2:0], rd_req & rd_first};
                end
            end
        end
    endgenerate

    assign data_vld   = vld_pipe[RD_LAT-1];
    assign data_first = first_pipe[RD_LAT-1];

    logic [1:0]       ph;
    logic [1:0]       ph_use;
    logic [1:0]       ph_next;
    logic [15:0]      held;
    logic [15:0]      held_next;
    logic             pend;
    logic             make_pend;
    logic [PIX_W-1:0] pend_pix;
    logic [PIX_W-1:0] pend_next;
    logic [PIX_W-1:0] now_pix;

    // Select the pixel for the arriving word and any pixel left for the next cycle
    always_comb begin
        ph_use    = data_first ? 2'd0 : ph;
        ph_next   = (ph_use == 2'd2) ? 2'd0 : ph_use + 2'd1;
        held_next = held;
        make_pend = 1'b0;
        pend_next = '0;
        now_pix   = '0;
        case (fmt)
            FMT_555, FMT_565: begin
                now_pix   = widen16(rd_data[15:0], fmt);
                pend_next = widen16(rd_data[31:16], fmt);
                make_pend = 1'b1;
            end
            FMT_PACK24: begin
                case (ph_use)
                    2'd0: begin
                        now_pix   = rd_data[23:0];
                        held_next = {8'h00, rd_data[31:24]};
                    end
                    2'd1: begin
                        now_pix   = {rd_data[15:0], held[7:0]};
                        held_next = rd_data[31:16];
                    end
                    default: begin
                        now_pix   = {rd_data[7:0], held};
                        pend_next = rd_data[31:8];
                        make_pend = 1'b1;
                    end
                endcase
            end
            default: begin
                now_pix = rd_data[23:0];
            end
        endcase
    end

    // Drive the pixel output and the unpack state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= '0;
            held      <= '0;
            pend      <= 1'b0;
            pend_pix  <= '0;
            pix_valid <= 1'b0;
            pix_rgb   <= '0;
        end else if (data_vld) begin
            ph        <= ph_next;
            held      <= held_next;
            pend      <= make_pend & en;
            pend_pix  <= pend_next;
            pix_valid <= en;
            pix_rgb   <= en ? now_pix : '0;
        end else if (pend) begin
            pend      <= 1'b0;
            pix_valid <= 1'b1;
            pix_rgb   <= pend_pix;
        end else begin
            pix_valid <= 1'b0;
            pix_rgb   <= '0;
        end
    end

endmodule

// File: rtl/scan_addr_gen.sv
// Scanout address generator top: shadow registers, fetch sequencer and
// pixel unpacker. Word addresses; memory returns data RD_LAT cycles after
// each request with no back-pressure.
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base_long,
    input  logic [ADDR_W-1:0] cfg_base_short,
    input  logic [31:0]       cfg_size,
    input  logic [31:0]       cfg_mode,
    input  logic              field_start,
    input  logic              field_short,
    input  logic              line_start,
    input  logic [31:0]       rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pix_valid,
    output logic [23:0]       pix_rgb
);

    scan_cfg_t         sh_cfg;
    logic [ADDR_W-1:0] start_addr;
    logic              field_load;
    logic              rd_first;

    scan_cfg_shadow #(.ADDR_W(ADDR_W)) shadow_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .field_short(field_short),
        .base_long  (cfg_base_long),
        .base_short (cfg_base_short),
        .size_word  (cfg_size),
        .mode_word  (cfg_mode),
        .cfg        (sh_cfg),
        .start_addr (start_addr),
        .field_load (field_load)
    );

    scan_fetch #(.ADDR_W(ADDR_W)) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (sh_cfg),
        .start_addr(start_addr),
        .field_load(field_load),
        .line_start(line_start),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_first  (rd_first)
    );

    scan_unpack #(.RD_LAT(RD_LAT)) unpack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sh_cfg.en),
        .fmt      (sh_cfg.fmt),
        .rd_req   (rd_req),
        .rd_first (rd_first),
        .rd_data  (rd_data),
        .pix_valid(pix_valid),
        .pix_rgb  (pix_rgb)
    );

endmodule

// File: rtl/scan_addr_gen_chk.sv
// Assertion checker for scan_addr_gen, attached with bind below.
module scan_addr_gen_chk
    import scan_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_first,
    input logic              sh_en,
    input pix_fmt_e          sh_fmt
);

    logic              seen_field;
    logic [ADDR_W-1:0] prev_addr;

    // Remember whether a field has started and the last read address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_field <= 1'b0;
            prev_addr  <= '0;
        end else begin
            if (field_start) seen_field <= 1'b1;
            if (rd_req)      prev_addr  <= rd_addr;
        end
    end

    // R1
    no_read_before_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> seen_field);

    // R9
    no_read_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> sh_en);

    // R6
    half_rate_16bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (sh_fmt == FMT_555 || sh_fmt == FMT_565)) |=> !rd_req);

    // R7
    packed_pacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_fmt == FMT_PACK24 && rd_req && $past(rd_req) && $past(rd_req, 2)) |-> !$past(rd_req, 3));

    // R3
    consecutive_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_first) |-> rd_addr == prev_addr + ADDR_W'(1));

endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_start(field_start),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_first   (rd_first),
    .sh_en      (sh_cfg.en),
    .sh_fmt     (sh_cfg.fmt)
);

// File: tb/scan_addr_gen_tb.sv
// Testbench: behavioural reference (queues of expected reads and pixels)
// compared against the outputs on every clock.
module scan_addr_gen_tb_top;

    localparam int ADDR_W = 24;
    localparam int RD_LAT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base_long = '0;
    logic [ADDR_W-1:0] cfg_base_short = '0;
    logic [31:0]       cfg_size = '0;
    logic [31:0]       cfg_mode = '0;
    logic              field_start = 1'b0;
    logic              field_short = 1'b0;
    logic              line_start = 1'b0;
    logic [31:0]       rd_data = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              pix_valid;
    logic [23:0]       pix_rgb;

    always #4 clk = ~clk;

    scan_addr_gen #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_long(cfg_base_long), .cfg_base_short(cfg_base_short),
        .cfg_size(cfg_size), .cfg_mode(cfg_mode),
        .field_start(field_start), .field_short(field_short), .line_start(line_start),
        .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    int    checks = 0;
    int    fails = 0;
    int    exp_addr[$];
    string exp_atag[$];
    int    exp_pix[$];
    string exp_ptag[$];
    int    m_fmt = 0;
    bit    m_en = 1'b0;
    bit    p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;
    int    req_seen = 0;
    int    pix_seen = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    logic [ADDR_W-1:0] hist [RD_LAT];

    function automatic int memfn(input int a);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1;
        return int'(x ^ {x[7:0], 8'hC3, x[23:16], 8'h5A});
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int wid5(input int v);
        return ((v << 3) | (v >> 2)) & 255;
    endfunction

    // Per-clock comparison against the reference queues and the memory model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!pix_valid) chk(pix_rgb == 0, "R11 idle pixel", int'(pix_rgb), 0);
            if (rd_req) begin
                req_seen++;
                chk(m_en, "R9 read while disabled", 1, 0);
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R5 unexpected read", int'(rd_addr), -1);
                end else begin
                    int    ea;
                    string et;
                    ea = exp_addr.pop_front();
                    et = exp_atag.pop_front();
                    chk(int'(rd_addr) == ea, et, int'(rd_addr), ea);
                end
                if (m_fmt < 2) chk(!p1, "R6 back-to-back read", 1, 0);
                if (m_fmt == 2) chk(!(p1 && p2 && p3), "R7 four reads in a row", 1, 0);
            end
            if (pix_valid) begin
                pix_seen++;
                if (exp_pix.size() == 0) begin
                    chk(1'b0, "R5 unexpected pixel", int'(pix_rgb), -1);
                end else begin
                    int    ep;
                    string pt;
                    ep = exp_pix.pop_front();
                    pt = exp_ptag.pop_front();
                    chk(int'(pix_rgb) == ep, pt, int'(pix_rgb), ep);
                end
            end
            p3 = p2; p2 = p1; p1 = rd_req;
        end
        rd_data = 32'(memfn(int'(hist[RD_LAT-1])));
        for (int k = RD_LAT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = rd_addr;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Builds the expected reads and pixels of one line; returns the next line's start
    task automatic model_line(input int ptr, input int words, input int fmt,
                              input string atag, input string ptag, output int first_addr);
        int bytes[$];
        first_addr = ptr;
        for (int w = 0; w < words; w++) begin
            int a, d;
            a = (ptr + w) & ((1 << ADDR_W) - 1);
            exp_addr.push_back(a);
            exp_atag.push_back((w == 0) ? atag : "R3 word address");
            d = memfn(a);
            if (fmt < 2) begin
                for (int h = 0; h < 2; h++) begin
                    int p, r, g, b;
                    p = (d >> (16 * h)) & 16'hFFFF;
                    b = wid5(p & 31);
                    if (fmt == 1) begin
                        r = wid5((p >> 11) & 31);
                        g = ((((p >> 5) & 63) << 2) | (((p >> 5) & 63) >> 4)) & 255;
                    end else begin
                        r = wid5((p >> 10) & 31);
                        g = wid5((p >> 5) & 31);
                    end
                    exp_pix.push_back((r << 16) | (g << 8) | b);
                    exp_ptag.push_back(ptag);
                end
            end else if (fmt == 3) begin
                exp_pix.push_back(d & 24'hFFFFFF);
                exp_ptag.push_back(ptag);
            end else begin
                for (int k = 0; k < 4; k++) bytes.push_back((d >> (8 * k)) & 255);
            end
        end
        if (fmt == 2) begin
            for (int k = 0; k + 2 < bytes.size(); k += 3) begin
                exp_pix.push_back((bytes[k+2] << 16) | (bytes[k+1] << 8) | bytes[k]);
                exp_ptag.push_back(ptag);
            end
        end
    endtask

    // Runs one field and checks that every expected read and pixel appeared
    task automatic run_field(input int bl, input int bs, input bit sh, input int words,
                             input int lines, input int stride, input int fmt, input bit en,
                             input int nstrobes, input bit disturb);
        int    ptr, fa, gap;
        string ptag, tov;
        ptag = (fmt < 2) ? "R6 16-bit pixel" : (fmt == 2) ? "R7 packed pixel" : "R8 wide pixel";
        tov = disturb ? "R10 shadowed config" : "";
        gap = 2 * words + RD_LAT + 8;
        @(negedge clk);
        cfg_base_long  = ADDR_W'(bl);
        cfg_base_short = ADDR_W'(bs);
        cfg_size       = {2'b00, 10'(stride), 10'(lines - 1), 10'(words - 1)};
        cfg_mode       = {28'h0, 2'(fmt), 1'b0, en};
        field_short    = sh;
        field_start    = 1'b1;
        m_fmt = fmt;
        m_en  = en;
        ptr = sh ? bs : bl;
        @(negedge clk);
        field_start = 1'b0;
        @(negedge clk);
        for (int s = 0; s < nstrobes; s++) begin
            line_start = 1'b1;
            if (en && s < lines) begin
                model_line(ptr, words, fmt,
                           (tov != "") ? tov : (s == 0) ? "R2 field base" : "R4 line stride",
                           (tov != "") ? tov : ptag, fa);
                ptr = fa + words + stride - 1;
            end
            @(negedge clk);
            line_start = 1'b0;
            if (disturb && s == 0) begin
                cfg_base_long  = cfg_base_long + ADDR_W'(100);
                cfg_base_short = cfg_base_short + ADDR_W'(200);
                cfg_size       = {2'b00, 10'd9, 10'd0, 10'd2};
                cfg_mode       = {28'h0, 2'd0, 1'b0, 1'b0};
            end
            repeat (gap) @(negedge clk);
        end
        repeat (RD_LAT + 6) @(negedge clk);
        chk(exp_addr.size() == 0, "R5 missing reads", exp_addr.size(), 0);
        chk(exp_pix.size() == 0, "R3 missing pixels", exp_pix.size(), 0);
        exp_addr.delete(); exp_atag.delete(); exp_pix.delete(); exp_ptag.delete();
    endtask

    initial begin
        for (int k = 0; k < RD_LAT; k++) hist[k] = '0;
        repeat (5) @(negedge clk);
        chk(rd_req == 1'b0, "R1 reset rd_req", int'(rd_req), 0);
        chk(pix_valid == 1'b0, "R1 reset pix_valid", int'(pix_valid), 0);
        chk(pix_rgb == 24'h0, "R1 reset pix_rgb", int'(pix_rgb), 0);
        rst_n = 1'b1;
        m_en = 1'b1;
        cfg_mode = 32'h1;
        cfg_size = {2'b00, 10'd1, 10'd3, 10'd3};
        repeat (3) begin
            @(negedge clk); line_start = 1'b1;
            @(negedge clk); line_start = 1'b0;
            repeat (10) @(negedge clk);
        end
        chk(req_seen == 0, "R1 no read before first field", req_seen, 0);
        // 5:6:5, long field, contiguous lines
        run_field(32'h1000, 32'h2000, 1'b0, 8, 3, 1, 1, 1'b1, 3, 1'b0);
        // 5:5:5, interlaced short field with surplus strobes
        run_field(32'h3000, 32'h3006, 1'b1, 6, 3, 7, 0, 1'b1, 5, 1'b0);
        // long field of the same interlaced pair
        run_field(32'h3000, 32'h3006, 1'b0, 6, 3, 7, 0, 1'b1, 3, 1'b0);
        // wide 32-bit with a skipping stride
        run_field(32'h4F0, 32'h0, 1'b0, 5, 2, 3, 3, 1'b1, 2, 1'b0);
        // packed 24-bit, whole groups then a leftover word count
        run_field(32'h5000, 32'h0, 1'b0, 6, 2, 1, 2, 1'b1, 2, 1'b0);
        run_field(32'h0, 32'h5100, 1'b1, 4, 2, 2, 2, 1'b1, 3, 1'b0);
        run_field(32'h5200, 32'h0, 1'b0, 5, 1, 1, 2, 1'b1, 1, 1'b0);
        // disabled field: no reads, no pixels
        pix_seen = 0;
        req_seen = 0;
        run_field(32'h6000, 32'h0, 1'b0, 4, 2, 1, 3, 1'b0, 3, 1'b0);
        chk(req_seen == 0, "R9 disabled reads", req_seen, 0);
        chk(pix_seen == 0, "R9 disabled pixels", pix_seen, 0);
        // mid-field configuration changes are ignored
        run_field(32'h7000, 32'h7800, 1'b0, 4, 3, 2, 3, 1'b1, 3, 1'b1);
        // following field picks up the new values
        run_field(32'h8000, 32'h0, 1'b0, 3, 2, 1, 1, 1'b1, 2, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule